// File: doc/BRIEF.md
# USB High-Speed Receive Path Controller

This block is the receive half of a USB 2.0 transceiver macrocell, sitting between the clock and data recovery stage and the link layer. Each cycle in which the recovered-bit strobe is high, it takes one line level and a single-ended-zero flag. While idle it watches the decoded stream for the start-of-packet synchronisation pattern. Once that pattern is found, it NRZI-decodes the following bits, throws away stuffed bits, and packs the remaining bits LSB first into bytes.

Each finished byte appears on an 8-bit bus together with a one-clock valid pulse. A packet-active flag frames the whole packet. It rises after the synchronisation pattern and falls when end-of-packet signalling is sampled. Seven decoded ones in a row is a bit-stuff violation. It raises an error flag for one clock and then ends the packet. Packet identifiers and CRC bytes are not interpreted: they are passed on as ordinary bytes. The same logic serves full speed, where the strobe comes roughly once every 40 clocks, and high speed, where it can come every clock.

Top module: `usbrx_receiver`

## Requirements
- R1: While reset is asserted and until the first packet, rx_active, rx_valid and rx_error are low.
- R2: NRZI decoding treats an unchanged line level as a one and a level change as a zero. A one that follows at least SYNC_MIN_ZEROS (6) decoded zeros is the end of the synchronisation pattern, and rx_active rises one clock after the strobe of that one. A shorter run of zeros followed by a one leaves rx_active low.
- R3: Every byte after the synchronisation pattern, the first (identifier) byte included, is delivered unchanged. The first data bit received lands in rx_data bit 0.
- R4: Once six consecutive decoded ones have been seen, the next bit is a stuffed zero and is dropped. The run count includes the final one of the synchronisation pattern.
- R5: rx_valid is high for the one clock after the strobe of a byte's eighth data bit. A byte slot that is stretched by stuffed bits therefore produces no pulse until the byte is complete.
- R6: rx_valid is high only while rx_active is high and rx_error is low, and never for two clocks in a row.
- R7: A strobed single-ended-zero during a packet lowers rx_active one clock later. Bits of an unfinished byte are discarded, and the block returns to hunting.
- R8: A decoded one arriving when six ones are already counted raises rx_error for exactly the following clock, with rx_active still high. rx_active is low the clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_strobe | input | 1 | High in a cycle that carries a recovered bit |
| line_level | input | 1 | Recovered line level (1 = J) |
| line_se0 | input | 1 | Recovered bit is single-ended zero |
| rx_active | output | 1 | Packet in progress |
| rx_valid | output | 1 | rx_data holds a new byte this clock |
| rx_error | output | 1 | Bit-stuff violation, one clock |
| rx_data | output | DATA_W | Received byte |

## Verification
At high speed, with a strobe every clock, the valid pulse for a packet's last byte falls in the same clock in which the end-of-packet signalling is sampled. The bench provokes this by following the last byte directly with single-ended-zero bits. It checks that the valid pulse lands while rx_active is still high and that rx_active falls exactly one clock later. When the last byte ends in a run of ones, the stuffed zero between them pushes the fall back by one further clock, and the bench predicts that shift from its own encoder.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_RECV  = 2'd1,
    ST_FAULT = 2'd2
  } rx_state_e;
endpackage

// File: rtl/usbrx_nrzi_dec.sv
module usbrx_nrzi_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic line_lvl,
  input  logic line_se0,
  output logic dec_bit
);
  logic prev_q, prev_d;

  always_comb begin
    prev_d = prev_q;
    if (strobe) prev_d = line_se0 ? 1'b1 : line_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end

  // no transition decodes to one
  assign dec_bit = (line_lvl == prev_q);
endmodule

// File: rtl/usbrx_destuff.sv
module usbrx_destuff #(
  parameter int RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seed,
  input  logic take_en,
  input  logic bit_in,
  output logic drop_bit,
  output logic stuff_err
);
  localparam int CW = $clog2(RUN + 1);

  logic [CW-1:0] ones_q, ones_d;
  logic          at_run;

  assign at_run    = (ones_q == CW'(RUN));
  assign drop_bit  = at_run & ~bit_in;
  assign stuff_err = at_run &  bit_in;

  always_comb begin
    ones_d = ones_q;
    if (seed)
      ones_d = CW'(1);
    else if (take_en) begin
      if (at_run || !bit_in) ones_d = '0;
      else                   ones_d = ones_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_d;
  end

  assert_run_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= CW'(RUN));
  assert_stuff_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_en && !seed && drop_bit) |=> (ones_q == '0));
endmodule

// File: rtl/usbrx_bytepack.sv
module usbrx_bytepack #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] hold,
  output logic         byte_vld
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sh_q, sh_d, hold_q, hold_d, sh_next;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          vld_q, vld_d;

  assign sh_next = {bit_in, sh_q[W-1:1]};

  always_comb begin
    sh_d   = sh_q;
    hold_d = hold_q;
    cnt_d  = cnt_q;
    vld_d  = 1'b0;
    if (clear)
      cnt_d = '0;
    else if (shift_en) begin
      sh_d = sh_next;
      if (cnt_q == CW'(W - 1)) begin
        cnt_d  = '0;
        hold_d = sh_next;
        vld_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      hold_q <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (shift_en) sh_q <= sh_d;
      if (vld_d)    hold_q <= hold_d;
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  assign hold     = hold_q;
  assign byte_vld = vld_q;

  assert_vld_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(hold_q));
endmodule

// File: rtl/usbrx_receiver.sv
module usbrx_receiver #(
  parameter int DATA_W         = 8,
  parameter int STUFF_RUN      = 6,
  parameter int SYNC_MIN_ZEROS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_strobe,
  input  logic              line_level,
  input  logic              line_se0,
  output logic              rx_active,
  output logic              rx_valid,
  output logic              rx_error,
  output logic [DATA_W-1:0] rx_data
);
  import usbrx_pkg::*;

  localparam int ZCW = $clog2(SYNC_MIN_ZEROS + 1);

  logic [1:0]     rsync_q;
  logic           rst_int_n;
  rx_state_e      state_q, state_d;
  logic [ZCW-1:0] zc_q, zc_d;
  logic           dec_bit, sync_hit, bit_take, drop_bit, stuff_err, pack_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  usbrx_nrzi_dec u_nrzi (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .strobe   (bit_strobe),
    .line_lvl (line_level),
    .line_se0 (line_se0),
    .dec_bit  (dec_bit)
  );

  assign sync_hit = bit_strobe && (state_q == ST_HUNT) && !line_se0 && dec_bit
                    && (zc_q == ZCW'(SYNC_MIN_ZEROS));
  assign bit_take = bit_strobe && (state_q == ST_RECV) && !line_se0;
  assign pack_en  = bit_take && !drop_bit && !stuff_err;

  usbrx_destuff #(.RUN(STUFF_RUN)) u_destuff (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .seed      (sync_hit),
    .take_en   (bit_take),
    .bit_in    (dec_bit),
    .drop_bit  (drop_bit),
    .stuff_err (stuff_err)
  );

  usbrx_bytepack #(.W(DATA_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clear    (sync_hit),
    .shift_en (pack_en),
    .bit_in   (dec_bit),
    .hold     (rx_data),
    .byte_vld (rx_valid)
  );

  always_comb begin
    state_d = state_q;
    zc_d    = zc_q;
    unique case (state_q)
      ST_HUNT: begin
        if (bit_strobe) begin
          if (line_se0 || dec_bit)            zc_d = '0;
          else if (zc_q != ZCW'(SYNC_MIN_ZEROS)) zc_d = zc_q + 1'b1;
          if (sync_hit) state_d = ST_RECV;
        end
      end
      ST_RECV: begin
        if (bit_strobe) begin
          if (line_se0)       state_d = ST_HUNT;
          else if (stuff_err) state_d = ST_FAULT;
        end
      end
      ST_FAULT: state_d = ST_HUNT;
      default:  state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_HUNT;
      zc_q    <= '0;
    end else begin
      state_q <= state_d;
      zc_q    <= zc_d;
    end
  end

  assign rx_active = (state_q != ST_HUNT);
  assign rx_error  = (state_q == ST_FAULT);

  assert_vld_in_pkt_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_valid |-> (rx_active && !rx_error));
  assert_err_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_error |=> (!rx_error && !rx_active));
  assert_eop_falls_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bit_strobe && line_se0 && state_q == ST_RECV) |=> !rx_active);
  assert_sync_rise_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    sync_hit |=> (rx_active && !rx_valid && !rx_error));
endmodule

// File: tb/test_usbrx_receiver.sv
module test_usbrx_receiver;
  localparam int RUN = 6;
  localparam int SMZ = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_strobe = 1'b0, line_level = 1'b1, line_se0 = 1'b0;
  logic rx_active, rx_valid, rx_error;
  logic [7:0] rx_data;

  always #2 clk = ~clk;

  usbrx_receiver i_usbrx_receiver (
    .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .line_level(line_level),
    .line_se0(line_se0), .rx_active(rx_active), .rx_valid(rx_valid),
    .rx_error(rx_error), .rx_data(rx_data)
  );

  int n_checks = 0, n_errors = 0, cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  // encoded stream
  logic lv_a[0:511];
  logic se_a[0:511];
  int   dcyc[0:511];
  int   byte_end[0:31];
  logic [7:0] byte_val[0:31];
  int ns, nb, sync_end, eop_idx, err_idx, ones;
  logic lvl;

  // monitor
  bit mon_on = 1'b0;
  int nv, rise_c, fall_c, err_n, err_c, wide;
  int vc[0:31];
  logic [7:0] vd[0:31];
  logic act_prev, vld_prev;

  always @(negedge clk) begin
    if (mon_on) begin
      if (rx_valid) begin
        if (nv < 32) begin vc[nv] = cyc; vd[nv] = rx_data; end
        nv++;
      end
      if (rx_active && !act_prev) rise_c = cyc;
      if (!rx_active && act_prev) fall_c = cyc;
      if (rx_error) begin err_n++; err_c = cyc; end
      if (rx_valid && vld_prev) wide++;
      act_prev = rx_active;
      vld_prev = rx_valid;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  always @(posedge clk) if (!done && cyc > 150000) begin
    done = 1'b1;
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic l, input logic s);
    lv_a[ns] = l; se_a[ns] = s; ns++;
  endtask

  task automatic push_dec(input logic d);
    if (!d) lvl = ~lvl;
    push(lvl, 1'b0);
  endtask

  task automatic start_pkt(input int nz);
    ns = 0; nb = 0; lvl = 1'b1; eop_idx = -1; err_idx = -1;
    for (int i = 0; i < 3; i++) push_dec(1'b1);
    for (int i = 0; i < nz; i++) push_dec(1'b0);
    push_dec(1'b1);
    sync_end = ns - 1;
    ones = 1;
  endtask

  task automatic add_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      push_dec(v[i]);
      if (i == 7) byte_end[nb] = ns - 1;
      ones = v[i] ? ones + 1 : 0;
      if (ones == RUN) begin push_dec(1'b0); ones = 0; end
    end
    byte_val[nb] = v;
    nb++;
  endtask

  task automatic add_zeros(input int n);
    for (int i = 0; i < n; i++) begin push_dec(1'b0); ones = 0; end
  endtask

  task automatic add_eop();
    eop_idx = ns;
    push(1'b0, 1'b1); push(1'b0, 1'b1);
    lvl = 1'b1;
    for (int i = 0; i < 3; i++) push(1'b1, 1'b0);
  endtask

  task automatic add_err();
    for (int i = 0; i <= RUN + 1; i++) begin
      push_dec(1'b1);
      ones++;
      if (ones == RUN + 1) begin err_idx = ns - 1; break; end
    end
    for (int i = 0; i < 4; i++) push_dec(1'b1);
  endtask

  task automatic play(input int per);
    nv = 0; rise_c = -1; fall_c = -1; err_n = 0; err_c = -1; wide = 0;
    act_prev = rx_active; vld_prev = rx_valid;
    @(posedge clk); #1;
    mon_on = 1'b1;
    for (int idx = 0; idx < ns; idx++) begin
      line_level = lv_a[idx]; line_se0 = se_a[idx]; bit_strobe = 1'b1;
      dcyc[idx] = cyc;
      @(posedge clk); #1;
      if (per > 1) begin
        bit_strobe = 1'b0;
        repeat (per - 1) begin @(posedge clk); #1; end
      end
    end
    bit_strobe = 1'b0; line_level = 1'b1; line_se0 = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    mon_on = 1'b0;
  endtask

  task automatic verify(input bit exp_err);
    chk(nv == nb, "R3 byte count", nv, nb);
    for (int b = 0; b < nb && b < nv && b < 32; b++) begin
      chk(vd[b] == byte_val[b], "R4 destuffed byte value", vd[b], byte_val[b]);
      chk(vc[b] == dcyc[byte_end[b]] + 1, "R5 valid cycle", vc[b], dcyc[byte_end[b]] + 1);
    end
    chk(rise_c == dcyc[sync_end] + 1, "R2 active rise", rise_c, dcyc[sync_end] + 1);
    chk(wide == 0, "R6 single-clock valid", wide, 0);
    if (exp_err) begin
      chk(err_n == 1, "R8 error pulse count", err_n, 1);
      chk(err_c == dcyc[err_idx] + 1, "R8 error cycle", err_c, dcyc[err_idx] + 1);
      chk(fall_c == err_c + 1, "R8 active falls after error", fall_c, err_c + 1);
    end else begin
      chk(err_n == 0, "R8 no error on legal stream", err_n, 0);
      chk(fall_c == dcyc[eop_idx] + 1, "R7 active fall at EOP", fall_c, dcyc[eop_idx] + 1);
    end
    chk(rx_active == 1'b0, "R7 idle after packet", rx_active, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rx_active && !rx_valid && !rx_error, "R1 outputs in reset",
        {rx_active, rx_valid, rx_error}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(!rx_active && !rx_valid && !rx_error, "R1 outputs after reset",
        {rx_active, rx_valid, rx_error}, 0);

    // R2: one zero short of the SYNC run is ignored
    start_pkt(SMZ - 1);
    for (int i = 0; i < 4; i++) push_dec(1'b1);
    play(1);
    chk(rise_c == -1 && err_n == 0 && nv == 0, "R2 short sync ignored", rise_c, -1);

    // R2: minimum-length SYNC is accepted
    start_pkt(SMZ); add_byte(8'hC3); add_eop(); play(1); verify(1'b0);

    // R3/R4/R5: sweep every byte value with its complement, high speed
    for (int v = 0; v < 256; v++) begin
      start_pkt(7); add_byte(8'(v)); add_byte(~8'(v)); add_eop();
      play(1); verify(1'b0);
    end

    // R4/R5: long run of ones, stuffed bits accumulate and skip byte slots
    start_pkt(7); for (int i = 0; i < 12; i++) add_byte(8'hFF); add_eop(); play(1); verify(1'b0);
    start_pkt(7); for (int i = 0; i < 12; i++) add_byte(8'h7E); add_eop(); play(1); verify(1'b0);
    start_pkt(7); add_byte(8'h3F); add_byte(8'hFC); add_eop(); play(1); verify(1'b0);

    // R5/R6: full-speed pacing, 40 clocks per bit
    start_pkt(7); for (int i = 0; i < 6; i++) add_byte(8'(i * 37 + 5)); add_eop(); play(40); verify(1'b0);
    start_pkt(7); for (int i = 0; i < 4; i++) add_byte(8'hFF); add_eop(); play(40); verify(1'b0);

    // R7: unfinished byte dropped at EOP
    start_pkt(7); add_byte(8'h5A); add_zeros(3); add_eop(); play(1); verify(1'b0);
    start_pkt(7); add_byte(8'h11); add_zeros(5); add_eop(); play(7); verify(1'b0);

    // R8: seven ones, high and full speed
    start_pkt(7); add_byte(8'hA5); add_err(); play(1); verify(1'b1);
    start_pkt(7); add_err(); play(1); verify(1'b1);
    start_pkt(7); add_byte(8'h00); add_byte(8'h1F); add_err(); play(40); verify(1'b1);

    // recovery after an error
    start_pkt(7); add_byte(8'h69); add_byte(8'h96); add_eop(); play(1); verify(1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule